// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 56-bit physical address. It walks a radix tree of page tables, four levels deep, in which every entry is 8 bytes wide. The caller supplies the root table's physical address, the level at which the walk starts, the access type, the privilege (user or supervisor), and two relaxations. One of them lets loads read execute-only pages. The other lets supervisor code touch data on user pages. The walker reads one entry at a time over a simple memory port that either reads or writes. It stops at the first leaf or fault. It checks the leaf's permissions and the alignment of large pages. When needed, it sets the accessed and dirty flags in the entry by writing the entry back to memory.

A walk ends with a one-cycle `done` pulse. When `res_fault` is zero, the result carries the physical address, the level of the leaf and the accumulated global flag. Otherwise `res_fault` gives the reason the walk failed.

Top module: `pt_walker`

## Requirements
- R1: At level L the entry is read from base + 8 * VA[12+9L +: 9]. The base is the root for the first read. There is only one memory request at a time: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R2: A read acknowledged with `mem_err` ends the walk with fault code 1 (access).
- R3: An entry with bit 0 (valid) clear, or with bit 2 (write) set and bit 1 (read) clear, ends the walk with fault code 2 (invalid).
- R4: An entry with bits 1, 2 and 3 (read, write, execute) all clear is a pointer. At level 0 a pointer gives fault code 2. At a higher level the next read uses entry bits [53:10] shifted left by 12 as its base, at level L-1.
- R5: `res_global` is the OR of bit 5 of every entry read during the walk.
- R6: The leaf's permission is checked against `req_acc` (0 load, 1 store, 2 or 3 fetch), and a failure gives fault code 3. A load needs read, or execute when `req_mxr` is set. A store needs write. A fetch needs execute. In user mode (`req_umode`=1) bit 4 (user) must be set. In supervisor mode a user page is allowed only for a load or store with `req_sum` set.
- R7: A leaf at level L>0 whose low 9L PPN bits are not all zero gives fault code 4 (misaligned). Otherwise those bits are taken from the VPN, and `res_level` reports L.
- R8: On success, `res_paddr` is {final PPN, VA[11:0]} and `res_fault` is 0.
- R9: The leaf needs an update when bit 6 (accessed) is clear, or when the access is a store and bit 7 (dirty) is clear. If the leaf needs an update and `req_ad_en` is 0, the walk gives fault code 5 and writes nothing.
- R10: If the leaf needs an update and `req_ad_en` is 1, the entry is written back to the same address with bit 6 set, and with bit 7 set for a store. A write acknowledged with `mem_err` gives fault code 1.
- R11: `done` is high for exactly one cycle. Each memory access takes two cycles plus the memory's wait before `mem_ack`. A request presented while `busy` is high is ignored.
- R12: After reset, `done`, `busy` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | start a walk (taken only when idle) |
| req_vaddr | input | 48 | virtual address |
| req_root | input | 56 | physical base of the starting table |
| req_level | input | 2 | starting level |
| req_acc | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_umode | input | 1 | 1 user, 0 supervisor |
| req_mxr | input | 1 | loads may read execute-only pages |
| req_sum | input | 1 | supervisor data access to user pages allowed |
| req_ad_en | input | 1 | hardware accessed/dirty update enabled |
| busy | output | 1 | a walk is in progress |
| mem_req | output | 1 | memory request, held until acknowledged |
| mem_we | output | 1 | request is a write |
| mem_addr | output | 56 | entry address |
| mem_wdata | output | 64 | entry write data |
| mem_ack | input | 1 | request completed |
| mem_err | input | 1 | request failed (with `mem_ack`) |
| mem_rdata | input | 64 | read data (with `mem_ack`) |
| done | output | 1 | one-cycle end-of-walk pulse |
| res_paddr | output | 56 | physical address |
| res_level | output | 2 | level of the leaf |
| res_global | output | 1 | global flag |
| res_fault | output | 3 | 0 ok, 1 access, 2 invalid, 3 permission, 4 misaligned, 5 update |

## Verification
The request is accepted on the edge where `req_valid` meets an idle walker. Each access then costs two edges plus the memory wait, so `done` becomes visible exactly N*(2+wait) edges later. Here N is the number of reads, plus one when there is a write-back. The bench counts edges from acceptance and samples on falling edges. It checks that `done` arrives at that exact count and has dropped again one cycle later. The same sample point is used to compare the fault code, address, level and global flag with a reference walk. That walk is computed from the bench's own copy of the tables before each request.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PPN_W = 44,
  localparam int PA_W = PPN_W + 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [47:0]     req_vaddr,
  input  logic [PA_W-1:0] req_root,
  input  logic [1:0]      req_level,
  input  logic [1:0]      req_acc,
  input  logic            req_umode,
  input  logic            req_mxr,
  input  logic            req_sum,
  input  logic            req_ad_en,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [63:0]     mem_rdata,
  output logic            done,
  output logic [PA_W-1:0] res_paddr,
  output logic [1:0]      res_level,
  output logic            res_global,
  output logic [2:0]      res_fault
);
  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic [47:0]      va;
  logic [1:0]       acc, lvl;
  logic             umode, mxr, sum, ad_en, glob;
  logic [PA_W-1:0]  base;
  logic [63:0]      pte_new;

  logic [8:0]       idx;
  logic [PPN_W-1:0] ppn, mask, vpn;
  logic             v, r, w, x, u, g, a, d, is_ptr, perm_ok, need_upd;
  logic             fin, descend, go_wr;
  logic [2:0]       fcode;

  assign idx      = va[12 + 9*lvl +: 9];
  assign mem_addr = base + PA_W'({idx, 3'b000});
  assign mem_req  = st != IDLE;
  assign mem_we   = st == WR;
  assign mem_wdata = pte_new;
  assign busy     = st != IDLE;
  assign res_level  = lvl;
  assign res_global = glob;

  assign {d, a, g, u, x, w, r, v} = mem_rdata[7:0];
  assign ppn    = mem_rdata[10 +: PPN_W];
  assign mask   = (PPN_W'(1) << (9*lvl)) - PPN_W'(1);
  assign vpn    = PPN_W'(va[47:12]);
  assign is_ptr = !r && !w && !x;
  assign perm_ok = (acc[1] ? x : acc[0] ? w : (r | (mxr & x))) &&
                   (umode ? u : (!u || (!acc[1] && sum)));
  assign need_upd = !a || (acc == 2'd1 && !d);

  always_comb begin
    fin = 1'b0; fcode = 3'd0; descend = 1'b0; go_wr = 1'b0;
    if (st == RD && mem_ack) begin
      if (mem_err)                   begin fin = 1'b1; fcode = 3'd1; end
      else if (!v || (w && !r))      begin fin = 1'b1; fcode = 3'd2; end
      else if (is_ptr) begin
        if (lvl == 2'd0)             begin fin = 1'b1; fcode = 3'd2; end
        else descend = 1'b1;
      end
      else if (!perm_ok)             begin fin = 1'b1; fcode = 3'd3; end
      else if ((ppn & mask) != '0)   begin fin = 1'b1; fcode = 3'd4; end
      else if (need_upd) begin
        if (!ad_en)                  begin fin = 1'b1; fcode = 3'd5; end
        else go_wr = 1'b1;
      end
      else fin = 1'b1;
    end else if (st == WR && mem_ack) begin
      fin = 1'b1;
      fcode = mem_err ? 3'd1 : 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; res_fault <= 3'd0; res_paddr <= '0;
      va <= '0; acc <= '0; lvl <= '0; umode <= 1'b0; mxr <= 1'b0;
      sum <= 1'b0; ad_en <= 1'b0; glob <= 1'b0; base <= '0; pte_new <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        res_fault <= fcode;
        st <= IDLE;
      end
      case (st)
        IDLE: if (req_valid) begin
          va <= req_vaddr; acc <= req_acc; umode <= req_umode;
          mxr <= req_mxr; sum <= req_sum; ad_en <= req_ad_en;
          base <= req_root; lvl <= req_level; glob <= 1'b0;
          st <= RD;
        end
        RD: if (mem_ack && !mem_err) begin
          glob <= glob | g;
          res_paddr <= {ppn | (vpn & mask), va[11:0]};
          if (descend) begin
            base <= {ppn, 12'b0};
            lvl  <= lvl - 2'd1;
          end
          if (go_wr) begin
            pte_new <= mem_rdata | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
            st <= WR;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [55:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [63:0] mem_rdata,
  input logic        done,
  input logic [2:0]  res_fault
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2
  read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && mem_err |=> done && res_fault == 3'd1);

  // R3
  not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && !mem_err && !mem_rdata[0] |=> done && res_fault == 3'd2);

  // R10
  wb_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[6] && mem_wdata[0]);
endmodule

bind pt_walker pt_walker_chk chk (.*);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0;
  logic [47:0] req_vaddr = '0;
  logic [55:0] req_root = '0;
  logic [1:0]  req_level = '0, req_acc = '0;
  logic        req_umode = 0, req_mxr = 0, req_sum = 0, req_ad_en = 0;
  logic        busy, mem_req, mem_we, done, res_global;
  logic [55:0] mem_addr, res_paddr;
  logic [63:0] mem_wdata;
  logic        mem_ack, mem_err;
  logic [63:0] mem_rdata;
  logic [1:0]  res_level;
  logic [2:0]  res_fault;

  pt_walker uut (.*);

  logic [63:0] mem [0:2047];
  int          mem_delay = 0, wcnt, wr_cnt;
  logic [55:0] last_addr, wr_addr;
  logic [63:0] wr_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= '0; wcnt <= 0; wr_cnt <= 0;
      last_addr <= '0; wr_addr <= '0; wr_data <= '0;
    end else begin
      mem_ack <= 0;
      if (mem_req && !mem_ack) begin
        if (wcnt == mem_delay) begin
          wcnt <= 0; mem_ack <= 1; last_addr <= mem_addr;
          if (mem_we) begin
            mem_err <= (mem_addr[13:12] == 2'd3);
            if (mem_addr[13:12] != 2'd3) begin
              wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
            end
          end else begin
            mem_err   <= (mem_addr >= 56'd16384);
            mem_rdata <= (mem_addr >= 56'd16384) ? 64'h0 : mem[mem_addr[13:3]];
          end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  function automatic logic [47:0] mkva(input int i3, i2, i1, i0, input logic [11:0] off);
    return {9'(i3), 9'(i2), 9'(i1), 9'(i0), off};
  endfunction

  function automatic string ftag(input logic [2:0] f);
    case (f)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R9";
      default: return "R8";
    endcase
  endfunction

  logic [2:0]  e_f;
  logic [55:0] e_pa, e_addr;
  logic [1:0]  e_lv;
  logic        e_g, e_wr;
  logic [63:0] e_wd;
  int          e_n;

  task automatic model(input logic [47:0] va, input logic [55:0] root, input logic [1:0] l0,
                       input logic [1:0] acc, input logic um, mx, sm, ad);
    logic [55:0] b = root;
    int l = l0;
    bit fin = 0;
    e_g = 0; e_n = 0; e_wr = 0; e_wd = '0; e_f = 0; e_pa = '0; e_lv = l0;
    for (int i = 0; i < 4 && !fin; i++) begin
      logic [63:0] e;
      logic [43:0] pp, mk, vp;
      bit ok;
      e_addr = b + {va[12 + 9*l +: 9], 3'b000};
      e_n++;
      if (e_addr >= 56'd16384) begin e_f = 1; fin = 1; continue; end
      e = mem[e_addr[13:3]];
      e_g |= e[5];
      e_lv = 2'(l);
      pp = e[53:10];
      if (!e[0] || (e[2] && !e[1])) begin e_f = 2; fin = 1; continue; end
      if (e[3:1] == 3'b000) begin
        if (l == 0) begin e_f = 2; fin = 1; end
        else begin b = {pp, 12'b0}; l--; end
        continue;
      end
      fin = 1;
      ok = acc[1] ? e[3] : acc[0] ? e[2] : (e[1] | (mx & e[3]));
      if (um) ok &= e[4];
      else if (e[4]) ok &= (!acc[1] && sm);
      if (!ok) begin e_f = 3; continue; end
      mk = (44'd1 << (9*l)) - 44'd1;
      if ((pp & mk) != 0) begin e_f = 4; continue; end
      vp = {8'b0, va[47:12]};
      e_pa = {pp | (vp & mk), va[11:0]};
      if (!e[6] || (acc == 2'd1 && !e[7])) begin
        if (!ad) begin e_f = 5; continue; end
        e_n++;
        e_wd = e | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
        if (e_addr[13:12] == 2'd3) e_f = 1;
        else e_wr = 1;
      end
    end
  endtask

  logic [2:0] got_f;

  task automatic walk(input logic [47:0] va, input logic [55:0] root, input logic [1:0] l0,
                      input logic [1:0] acc, input logic um, mx, sm, ad, input int dly, input bit poke);
    int cyc = 0, w0;
    model(va, root, l0, acc, um, mx, sm, ad);
    mem_delay = dly;
    w0 = wr_cnt;
    req_vaddr = va; req_root = root; req_level = l0; req_acc = acc;
    req_umode = um; req_mxr = mx; req_sum = sm; req_ad_en = ad; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    while (!done && cyc < 100) begin
      if (poke && cyc == 0) begin req_valid = 1; req_vaddr = va ^ 48'h1000; req_level = 2'd0; end
      else req_valid = 0;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    req_valid = 0;
    got_f = res_fault;
    check(res_fault == e_f, ftag(e_f), 64'(res_fault), 64'(e_f));
    check(cyc == e_n * (2 + dly), "R11", 64'(cyc), 64'(e_n * (2 + dly)));
    check(last_addr == (e_wr || e_f == 0 || e_f == 5 || e_f == 4 || e_f == 3 || e_f == 2 ? e_addr : e_addr) ,
          "R1", 64'(last_addr), 64'(e_addr));
    if (e_f == 0) begin
      check(res_paddr == e_pa, "R8", 64'(res_paddr), 64'(e_pa));
      check(res_level == e_lv, "R7", 64'(res_level), 64'(e_lv));
      check(res_global == e_g, "R5", 64'(res_global), 64'(e_g));
    end
    if (e_wr) begin
      check(wr_cnt == w0 + 1 && wr_addr == e_addr && wr_data == e_wd, "R10", wr_data, e_wd);
      mem[wr_addr[13:3]] = wr_data;
    end else check(wr_cnt == w0, "R9", 64'(wr_cnt - w0), 64'd0);
    @(posedge clk); @(negedge clk);
    check(!done, "R11", 64'(done), 64'd0);
  endtask

  task automatic fill_random();
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 512; i++) begin
        int t = int'($urandom % 8);
        logic [43:0] pp;
        if (t == 0) mem[p*512 + i] = pte(44'($urandom), 8'($urandom) & 8'hFE);
        else if (t == 1) mem[p*512 + i] = pte(44'($urandom), 8'h05 | (8'($urandom) & 8'hF8));
        else if (t < 4) begin
          pp = ($urandom % 8 == 0) ? 44'h100 : 44'(p + 1);
          mem[p*512 + i] = pte(pp, 8'h01 | (8'($urandom) & 8'hF0));
        end else begin
          pp = {12'($urandom), 32'($urandom)};
          if ($urandom % 2 == 1) pp[26:0] = '0;
          mem[p*512 + i] = pte(pp, (8'($urandom) & 8'hFE) | 8'h03);
        end
      end
  endtask

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FG = 8'h20, FA = 8'h40, FD = 8'h80;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !busy && !mem_req, "R12", {61'b0, done, busy, mem_req}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !busy && !mem_req, "R12", {61'b0, done, busy, mem_req}, 64'd0);

    mem[0*512 + 1]  = pte(44'd1, FV | FG);
    mem[1*512 + 2]  = pte(44'd2, FV);
    mem[2*512 + 3]  = pte(44'd3, FV);
    mem[3*512 + 4]  = pte(44'h12345, FV | FR | FW | FX | FA | FD);
    mem[3*512 + 5]  = pte(44'h222, FV | FR | FW);
    mem[2*512 + 6]  = pte(44'h4400, FV | FR | FW);
    mem[2*512 + 7]  = pte(44'h4401, FV | FR | FA);
    mem[3*512 + 6]  = pte(44'd0, FV);
    mem[3*512 + 7]  = pte(44'h9, FV | FW);
    mem[1*512 + 9]  = pte(44'h100, FV);
    mem[3*512 + 10] = pte(44'h10, FV | FR | FU | FA);
    mem[3*512 + 11] = pte(44'h11, FV | FX | FU | FA);
    mem[3*512 + 12] = pte(44'h12, FV | FX | FA);

    // R1 R4 R5 R8: full four-level walk, no memory wait, then with wait
    walk(mkva(1, 2, 3, 4, 12'hABC), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd0 && res_paddr == 56'h12345ABC, "R4", res_paddr, 64'h12345ABC);
    walk(mkva(1, 2, 3, 4, 12'h123), 56'h0, 2'd3, 2'd1, 0, 0, 0, 0, 2, 0);
    // R11: a second request while busy is ignored
    walk(mkva(1, 2, 3, 4, 12'h777), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 1, 1);
    check(res_paddr == 56'h12345777, "R11", res_paddr, 64'h12345777);
    // R9: update needed but disabled
    walk(mkva(1, 2, 3, 5, 12'h0), 56'h0, 2'd3, 2'd1, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd5, "R9", 64'(got_f), 64'd5);
    // R10: write-back hits a failing region
    walk(mkva(1, 2, 3, 5, 12'h0), 56'h0, 2'd3, 2'd1, 0, 0, 0, 1, 0, 0);
    check(got_f == 3'd1, "R10", 64'(got_f), 64'd1);
    // R7 R10: aligned superpage at level 1, store updates A and D
    walk(mkva(1, 2, 6, 300, 12'h456), 56'h0, 2'd3, 2'd1, 0, 0, 0, 1, 1, 0);
    check(got_f == 3'd0 && res_level == 2'd1, "R7", res_paddr, {44'h4400 | 44'd300, 12'h456});
    check(mem[2*512 + 6][7:6] == 2'b11, "R10", 64'(mem[2*512 + 6][7:6]), 64'd3);
    walk(mkva(1, 2, 7, 0, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd4, "R7", 64'(got_f), 64'd4);
    // R4: pointer at level 0
    walk(mkva(1, 2, 3, 6, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd2, "R4", 64'(got_f), 64'd2);
    // R3: write without read, and all-zero entry
    walk(mkva(1, 2, 3, 7, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd2, "R3", 64'(got_f), 64'd2);
    walk(mkva(1, 2, 3, 8, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 3, 0);
    // R2: next table outside memory
    walk(mkva(1, 9, 0, 0, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd1, "R2", 64'(got_f), 64'd1);
    // R6: privilege, SUM and MXR cases
    walk(mkva(1, 2, 3, 10, 12'h0), 56'h0, 2'd3, 2'd0, 1, 0, 0, 0, 0, 0);
    check(got_f == 3'd0, "R6", 64'(got_f), 64'd0);
    walk(mkva(1, 2, 3, 10, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    check(got_f == 3'd3, "R6", 64'(got_f), 64'd3);
    walk(mkva(1, 2, 3, 10, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 1, 0, 0, 0);
    walk(mkva(1, 2, 3, 11, 12'h0), 56'h0, 2'd3, 2'd2, 0, 0, 1, 0, 0, 0);
    check(got_f == 3'd3, "R6", 64'(got_f), 64'd3);
    walk(mkva(1, 2, 3, 11, 12'h0), 56'h0, 2'd3, 2'd2, 1, 0, 0, 0, 0, 0);
    walk(mkva(1, 2, 3, 12, 12'h0), 56'h0, 2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    walk(mkva(1, 2, 3, 12, 12'h0), 56'h0, 2'd3, 2'd0, 0, 1, 0, 0, 0, 0);
    check(got_f == 3'd0, "R6", 64'(got_f), 64'd0);
    walk(mkva(1, 2, 3, 10, 12'h0), 56'h0, 2'd3, 2'd1, 1, 0, 0, 0, 0, 0);
    // R1: walk starting below the top level
    walk(mkva(0, 0, 3, 4, 12'h5), 56'h2000, 2'd1, 2'd0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 400; k++) begin
      if (k % 100 == 0) fill_random();
      walk({16'($urandom), 32'($urandom)}, 56'($urandom % 4) << 12, 2'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom % 4), 0);
    end
    finish_run();
  end
endmodule